// File: doc/BRIEF.md
# Read/Write Access Scheduler for a Split-Port Burst Memory

This block decides, once per base clock cycle, whether a memory with a separate read port and write port begins a new read access, a new write access, or nothing. Every access occupies the memory for two base clock cycles. For that reason, two accesses of the same kind may not begin on consecutive cycles. A read and a write, however, may follow one another back to back.

The requester drives two active-low select lines and a shared address bus. The block registers these inputs on a rising edge. On the following rising edge it commits a decision. For that decision it raises a one-cycle start pulse for the chosen kind of access and loads the address into that kind's own address register.

The decision rests on a three-state history of what was started on the previous cycle:

- `HIST_IDLE`: nothing was started.
- `HIST_RD`: a read was started.
- `HIST_WR`: a write was started.

The transitions are as follows:

- **Read grant** moves the history to `HIST_RD`. It happens when a read is requested and the history is not `HIST_RD`.
- **Write grant** moves the history to `HIST_WR`. It happens when a write is requested, the history is not `HIST_WR`, and no read was granted.
- **Drop** moves the history to `HIST_IDLE`. It happens when neither of the above applies.

A request that cannot be served is discarded. The requester must present it again.

Top module: `dp_burst_sched`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it rises, `rd_start` and `wr_start` are 0 and `rd_addr` and `wr_addr` are 0. The history resets to `HIST_IDLE`.
- R2: A select counts as active when it is 0. Selects and `addr_in` sampled on rising edge N produce their start pulse in the cycle that follows rising edge N+1.
- R3: At most one of `rd_start` and `wr_start` is 1 in any cycle.
- R4: A read request sampled while the history is `HIST_RD` is ignored. As a result, `rd_start` is never 1 on two consecutive cycles.
- R5: A write request sampled while the history is `HIST_WR` is ignored. As a result, `wr_start` is never 1 on two consecutive cycles.
- R6: When both selects are active and the history is `HIST_IDLE`, the read is started.
- R7: When both selects are active and the history is `HIST_RD`, the write is started.
- R8: When both selects are active and the history is `HIST_WR`, the read is started.
- R9: When both selects are held active from an idle state, the start pulses alternate read, write, read, write, beginning with a read.
- R10: `rd_addr` takes the sampled address only when a read is started, and `wr_addr` only when a write is started. Otherwise each holds its value.
- R11: A request that is ignored or that loses arbitration is not kept. No start pulse follows from it once the select is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| rd_sel_n | input | 1 | Read request, active low |
| wr_sel_n | input | 1 | Write request, active low |
| addr_in | input | ADDR_W | Address for the request being presented |
| rd_start | output | 1 | One-cycle pulse: a read access begins |
| wr_start | output | 1 | One-cycle pulse: a write access begins |
| rd_addr | output | ADDR_W | Address of the most recently started read |
| wr_addr | output | ADDR_W | Address of the most recently started write |

## Verification
A read request and a write request can land in the same cycle. In that cycle the arbitration and the same-kind blocking rule act on one decision together.

The bench provokes this in two ways. Directed runs hold both selects low from idle, after a read, and after a write. Random stimulus also drives both selects low often.

Each outcome is judged against a model in the bench that follows the history rules. That model also predicts which address register must move and which must hold.

// File: rtl/dp_burst_sched_pkg.sv
package dp_burst_sched_pkg;

    typedef enum logic [1:0] {
        HIST_IDLE = 2'd0,
        HIST_RD   = 2'd1,
        HIST_WR   = 2'd2
    } hist_e;

    localparam int unsigned NUM_PORTS = 2;
    localparam int unsigned PORT_RD   = 0;
    localparam int unsigned PORT_WR   = 1;

endpackage

// File: rtl/dp_sched_sampler.sv
module dp_sched_sampler #(
    parameter int unsigned ADDR_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_sel_n,
    input  logic              wr_sel_n,
    input  logic [ADDR_W-1:0] addr_in,
    output logic              rd_req_q,
    output logic              wr_req_q,
    output logic [ADDR_W-1:0] addr_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_req_q <= 1'b0;
            wr_req_q <= 1'b0;
            addr_q   <= '0;
        end else begin
            rd_req_q <= ~rd_sel_n;
            wr_req_q <= ~wr_sel_n;
            addr_q   <= addr_in;
        end
    end

endmodule

// File: rtl/dp_sched_fsm.sv
module dp_sched_fsm
    import dp_burst_sched_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rd_req_q,
    input  logic                 wr_req_q,
    output logic [NUM_PORTS-1:0] grant,
    output logic                 rd_start,
    output logic                 wr_start
);

    hist_e hist_q;
    hist_e hist_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hist_q <= HIST_IDLE;
        end else begin
            hist_q <= hist_d;
        end
    end

    always_comb begin
        grant  = '0;
        hist_d = HIST_IDLE;
        unique case (hist_q)
            HIST_IDLE: begin
                if (rd_req_q) begin
                    grant[PORT_RD] = 1'b1;
                    hist_d         = HIST_RD;
                end else if (wr_req_q) begin
                    grant[PORT_WR] = 1'b1;
                    hist_d         = HIST_WR;
                end
            end
            HIST_RD: begin
                if (wr_req_q) begin
                    grant[PORT_WR] = 1'b1;
                    hist_d         = HIST_WR;
                end
            end
            HIST_WR: begin
                if (rd_req_q) begin
                    grant[PORT_RD] = 1'b1;
                    hist_d         = HIST_RD;
                end
            end
            default: begin
                hist_d = HIST_IDLE;
            end
        endcase
    end

    always_comb begin
        rd_start = (hist_q == HIST_RD);
        wr_start = (hist_q == HIST_WR);
    end

    AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(grant) <= 1); // R3
    AST_RD_AFTER_RD: assert property (@(posedge clk) disable iff (!rst_n)
        (hist_q == HIST_RD) |-> !grant[PORT_RD]); // R4
    AST_WR_AFTER_WR: assert property (@(posedge clk) disable iff (!rst_n)
        (hist_q == HIST_WR) |-> !grant[PORT_WR]); // R5
    AST_BOTH_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req_q && wr_req_q && hist_q == HIST_IDLE) |=> rd_start); // R6
    AST_BOTH_AFTER_RD: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req_q && wr_req_q && hist_q == HIST_RD) |=> wr_start); // R7
    AST_BOTH_AFTER_WR: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req_q && wr_req_q && hist_q == HIST_WR) |=> rd_start); // R8
    AST_NO_PHANTOM: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_req_q && !wr_req_q) |=> (!rd_start && !wr_start)); // R11

endmodule

// File: rtl/dp_sched_addr_regs.sv
module dp_sched_addr_regs
    import dp_burst_sched_pkg::*;
#(
    parameter int unsigned ADDR_W = 20
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_PORTS-1:0] load,
    input  logic [ADDR_W-1:0]    addr_q,
    output logic [ADDR_W-1:0]    port_addr [NUM_PORTS]
);

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                port_addr[p] <= '0;
            end else if (load[p]) begin
                port_addr[p] <= addr_q;
            end
        end

        AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            !load[p] |=> $stable(port_addr[p])); // R10
    end

endmodule

// File: rtl/dp_burst_sched.sv
module dp_burst_sched
    import dp_burst_sched_pkg::*;
#(
    parameter int unsigned ADDR_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_sel_n,
    input  logic              wr_sel_n,
    input  logic [ADDR_W-1:0] addr_in,
    output logic              rd_start,
    output logic              wr_start,
    output logic [ADDR_W-1:0] rd_addr,
    output logic [ADDR_W-1:0] wr_addr
);

    logic                 rd_req_q;
    logic                 wr_req_q;
    logic [ADDR_W-1:0]    addr_q;
    logic [NUM_PORTS-1:0] grant;
    logic [ADDR_W-1:0]    port_addr [NUM_PORTS];

    dp_sched_sampler #(.ADDR_W(ADDR_W)) u_sampler (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_sel_n (rd_sel_n),
        .wr_sel_n (wr_sel_n),
        .addr_in  (addr_in),
        .rd_req_q (rd_req_q),
        .wr_req_q (wr_req_q),
        .addr_q   (addr_q)
    );

    dp_sched_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_req_q (rd_req_q),
        .wr_req_q (wr_req_q),
        .grant    (grant),
        .rd_start (rd_start),
        .wr_start (wr_start)
    );

    dp_sched_addr_regs #(.ADDR_W(ADDR_W)) u_addr (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (grant),
        .addr_q    (addr_q),
        .port_addr (port_addr)
    );

    assign rd_addr = port_addr[PORT_RD];
    assign wr_addr = port_addr[PORT_WR];

    AST_START_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_start && wr_start)); // R3
    AST_RD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_start |=> !rd_start); // R4
    AST_WR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_start |=> !wr_start); // R5

endmodule

// File: tb/dp_burst_sched_bench.sv
module dp_burst_sched_bench;

    localparam int unsigned AW = 20;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rd_sel_n = 1'b1;
    logic          wr_sel_n = 1'b1;
    logic [AW-1:0] addr_in = '0;
    logic          rd_start, wr_start;
    logic [AW-1:0] rd_addr, wr_addr;

    int unsigned checks = 0;
    int unsigned fails  = 0;
    bit          done   = 1'b0;

    // model: 0 idle, 1 read started, 2 write started
    int unsigned   m_hist = 0;
    bit            m_rq = 0, m_wq = 0;
    logic [AW-1:0] m_addr = '0;
    bit            e_rd = 0, e_wr = 0;
    logic [AW-1:0] e_ra = '0, e_wa = '0;

    always #2 clk = ~clk;

    dp_burst_sched #(.ADDR_W(AW)) u_dp_burst_sched (
        .clk(clk), .rst_n(rst_n), .rd_sel_n(rd_sel_n), .wr_sel_n(wr_sel_n),
        .addr_in(addr_in), .rd_start(rd_start), .wr_start(wr_start),
        .rd_addr(rd_addr), .wr_addr(wr_addr)
    );

    function automatic bit grant_rd(bit rq, int unsigned h);
        return rq && (h != 1);
    endfunction

    function automatic bit grant_wr(bit rq, bit wq, int unsigned h);
        return wq && (h != 2) && !grant_rd(rq, h);
    endfunction

    task automatic check(bit ok, string tag, logic [AW-1:0] act, logic [AW-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // one cycle: update model for the rising edge just passed, compare, drive
    task automatic cycle(bit rs, bit ws, logic [AW-1:0] a, string tag);
        @(negedge clk);
        e_rd = grant_rd(m_rq, m_hist);
        e_wr = grant_wr(m_rq, m_wq, m_hist);
        if (e_rd) e_ra = m_addr;
        if (e_wr) e_wa = m_addr;
        m_hist = e_rd ? 1 : (e_wr ? 2 : 0);
        m_rq   = !rd_sel_n;
        m_wq   = !wr_sel_n;
        m_addr = addr_in;
        check(rd_start == e_rd, {tag, " rd_start"}, AW'(rd_start), AW'(e_rd));
        check(wr_start == e_wr, {tag, " wr_start"}, AW'(wr_start), AW'(e_wr));
        check(!(rd_start && wr_start), "R3 single start", AW'({rd_start, wr_start}), '0);
        check(rd_addr == e_ra, "R10 rd_addr", rd_addr, e_ra);
        check(wr_addr == e_wa, "R10 wr_addr", wr_addr, e_wa);
        rd_sel_n = rs;
        wr_sel_n = ws;
        addr_in  = a;
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        bit seen_rd;
        bit seen_wr;

        void'($urandom(32'd5171));
        repeat (3) @(negedge clk);
        check(rd_start == 0 && wr_start == 0, "R1 starts in reset", AW'({rd_start, wr_start}), '0);
        check(rd_addr == 0 && wr_addr == 0, "R1 addrs in reset", rd_addr | wr_addr, '0);
        rst_n = 1'b1;
        cycle(1, 1, 20'h00000, "R1 idle after reset");
        check(rd_start == 0 && wr_start == 0, "R1 first cycle", AW'({rd_start, wr_start}), '0);

        // R2: a lone read shows up two edges later
        cycle(0, 1, 20'h0A11A, "R2 read");
        cycle(1, 1, 20'h00000, "R2 read");
        cycle(1, 1, 20'h00000, "R2 read");
        check(rd_start == 1 && rd_addr == 20'h0A11A, "R2 read latency", rd_addr, 20'h0A11A);
        cycle(1, 1, 20'h00000, "R2 idle");

        // R4: back-to-back reads, second dropped; R11 not replayed
        cycle(0, 1, 20'h00111, "R4 rd-rd");
        cycle(0, 1, 20'h00222, "R4 rd-rd");
        cycle(1, 1, 20'h00000, "R4 rd-rd");
        cycle(1, 1, 20'h00000, "R4 rd-rd");
        check(rd_start == 0 && rd_addr == 20'h00111, "R11 dropped read", rd_addr, 20'h00111);
        cycle(1, 1, 20'h00000, "R11 idle");

        // R5: back-to-back writes
        cycle(1, 0, 20'h00333, "R5 wr-wr");
        cycle(1, 0, 20'h00444, "R5 wr-wr");
        cycle(1, 1, 20'h00000, "R5 wr-wr");
        cycle(1, 1, 20'h00000, "R5 wr-wr");
        check(wr_start == 0 && wr_addr == 20'h00333, "R5 second write ignored", wr_addr, 20'h00333);

        // R6/R7/R8/R9: both held from idle alternate starting with read
        cycle(1, 1, 20'h00000, "R6 idle");
        for (int i = 0; i < 8; i++) begin
            cycle(0, 0, AW'(20'h10000 + i), "R9 both held");
            if (i >= 2) begin
                check(rd_start == ((i % 2) == 0), "R9 alternation rd", AW'(rd_start), AW'((i % 2) == 0));
                check(wr_start == ((i % 2) == 1), "R9 alternation wr", AW'(wr_start), AW'((i % 2) == 1));
            end
            if (i == 2) check(rd_start == 1, "R6 idle both reads first", AW'(rd_start), 1);
            if (i == 3) check(wr_start == 1, "R7 after read both write", AW'(wr_start), 1);
            if (i == 4) check(rd_start == 1, "R8 after write both read", AW'(rd_start), 1);
        end
        cycle(1, 1, 20'h00000, "R11 release");
        cycle(1, 1, 20'h00000, "R11 release");
        cycle(1, 1, 20'h00000, "R11 release");
        check(rd_start == 0 && wr_start == 0, "R11 loser not queued", AW'({rd_start, wr_start}), '0);

        // constrained random: both low often
        seen_rd = 0;
        seen_wr = 0;
        for (int n = 0; n < 3000; n++) begin
            int unsigned r;
            r = $urandom % 4;
            cycle(r[0], r[1], AW'($urandom), "R2 random");
            seen_rd |= rd_start;
            seen_wr |= wr_start;
        end
        check(seen_rd && seen_wr, "R2 random saw both kinds", AW'({seen_rd, seen_wr}), AW'(3));
        cycle(1, 1, 20'h00000, "R2 drain");
        cycle(1, 1, 20'h00000, "R2 drain");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule